// File: doc/BRIEF.md
# Serial Memory Slave Front End with Transfer Pause

This block is the serial side of a small byte-addressed memory. A host drives a chip-select line, a serial clock and a serial data line. The block gathers opcode, address and data bytes, most significant bit first. It returns read data and status on a serial output that has its own output-enable. Clock modes 0 and 3 both work, because input bits are taken on rising clock edges and output bits move on falling edges, whatever level the clock rests at.

The storage array and the write-protection policy sit outside the block. For reads, the block presents an address with a one-cycle request pulse and takes the byte on `rd_data` in the next cycle. For writes, it hands each data byte over with a valid pulse and the current address. When chip select rises after a complete write command, it raises `wr_start` for one cycle, provided the external policy grants the write on `wr_grant`. The write-enable latch is also external and is driven by set and clear pulses.

A pause input lets the host stop a transfer partway through and resume it later. The pause is entered or left only when the pause line changes while the serial clock is low. While paused, the serial output is released and clock and data activity is ignored. All pins are sampled through a synchronizer into the block's system clock, so the serial clock must be several times slower than `clk`.

Top module: `spi_mem_slave`

## Requirements
- R1: Input bits are captured on rising serial-clock edges, most significant bit first; every eighth captured bit completes a byte.
- R2: The serial output changes only after falling serial-clock edges and shifts read bytes out most significant bit first, so that a host sampling on rising edges reads them correctly in clock mode 0 (clock idles low) and in clock mode 3 (clock idles high).
- R3: While chip select is high, `so_oe` is 0 and the bit counter and shift registers are cleared, so any partial byte is discarded.
- R4: A command is decoded from the first complete byte after a chip-select falling edge; earlier activity has no influence on it.
- R5: A WRITE (opcode 0x02) that has its opcode, one address byte and at least one full data byte, and that ends on a byte boundary, gives a one-cycle `wr_start` pulse with `wr_to_status`=0 when chip select rises and `wr_grant` is 1. A write-status command (opcode 0x01) that has at least one full data byte does the same with `wr_to_status`=1.
- R6: No `wr_start` is produced when chip select rises in the middle of a byte, when a write command has no data byte, or when `wr_grant` is 0.
- R7: READ (opcode 0x03) takes one address byte and then returns `rd_data` for that address. The address advances by one for each further byte and wraps from 0xFF to 0x00.
- R8: Read-status (opcode 0x05) returns `status_in` in every byte that follows the opcode.
- R9: An enable opcode (0x06) gives a `wel_set` pulse, and a disable opcode (0x04) gives a `wel_clr` pulse, when chip select rises after exactly one full byte. Any other opcode, or an extra byte, gives no pulse.
- R10: The block pauses when `hold_n` falls while the serial clock is low; `so_oe` then goes to 0. A fall of `hold_n` while the clock is high does not pause the block.
- R11: While paused, serial-clock and data activity is ignored. The pause ends when `hold_n` rises while the clock is low, and the transfer continues from the bit where it stopped.
- R12: Each WRITE data byte gives a one-cycle `wr_data_valid` pulse carrying the byte and its address; the address then advances by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause request |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| mem_addr | output | ADDR_W | Current array address |
| rd_req | output | 1 | One-cycle read request at `mem_addr` |
| rd_data | input | BYTE_W | Array byte, valid the cycle after `rd_req` |
| status_in | input | BYTE_W | Status byte returned by read-status |
| wr_data | output | BYTE_W | Data byte for a write |
| wr_data_valid | output | 1 | One-cycle strobe for `wr_data` |
| wr_to_status | output | 1 | Started write targets status (1) or array (0) |
| wel_set | output | 1 | Set the write-enable latch |
| wel_clr | output | 1 | Clear the write-enable latch |
| wr_grant | input | 1 | Protection policy allows the pending write |
| wr_start | output | 1 | Start the internal write cycle |

## Verification
If the bit counter is off by one, every later byte is misaligned. The next decoded opcode is then wrong, and `wel_set` or `wr_start` appears or fails to appear at the very next chip-select rise. A wrong pause state shows within a few system clocks, as `so_oe` at the wrong level, or as a read byte shifted by the edges that were wrongly counted or skipped. A wrong address or a late load of read data shows in the first read byte returned after the address, or at the wrap from 0xFF.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    // Command codes decoded from the first byte of a selection
    localparam logic [7:0] OPC_WRSR  = 8'h01;
    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_WRDI  = 8'h04;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_WREN  = 8'h06;

    // Where the sequencer stands inside a selection
    typedef enum logic [1:0] {
        PH_OPC  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_SKIP = 2'd3
    } phase_e;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    assign stage_d[0] = din;

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_chain
            assign stage_d[g] = stage_q[g-1];
        end
        for (genvar g = 0; g < STAGES; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spi_mem_hold.sv
module spi_mem_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_hi,
    input  logic sck_s,
    input  logic hold_n_s,
    output logic held
);
    typedef struct packed {
        logic hold_prev;
        logic held;
    } hold_t;

    hold_t hq_q, hq_d;
    logic  hold_fall, hold_rise;

    always_comb begin
        hq_d           = hq_q;
        hq_d.hold_prev = hold_n_s;
        hold_fall      = hq_q.hold_prev & ~hold_n_s;
        hold_rise      = ~hq_q.hold_prev & hold_n_s;
        if (cs_hi) begin
            hq_d.held = 1'b0;
        end else if (!hq_q.held && hold_fall && !sck_s) begin
            hq_d.held = 1'b1;
        end else if (hq_q.held && hold_rise && !sck_s) begin
            hq_d.held = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hq_q <= '{hold_prev: 1'b1, held: 1'b0};
        else        hq_q <= hq_d;
    end

    assign held = hq_q.held;

    AST_HOLD_ENTER_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hq_q.held) |-> !$past(sck_s)); // R10
    AST_HOLD_EXIT_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hq_q.held) && !$past(cs_hi)) |-> !$past(sck_s)); // R11
endmodule

// File: rtl/spi_mem_shift.sv
module spi_mem_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_hi,
    input  logic              held,
    input  logic              sck_s,
    input  logic              si_s,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              bit_zero,
    output logic              so_bit
);
    localparam int              CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic              sck_prev;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] rx_sr;
        logic [BYTE_W-1:0] tx_sr;
        logic              so;
        logic              done;
        logic [BYTE_W-1:0] rx_byte;
    } shift_t;

    shift_t sq_q, sq_d;
    logic   rise, fall;
    logic [BYTE_W-1:0] rx_next;

    always_comb begin
        sq_d          = sq_q;
        sq_d.done     = 1'b0;
        sq_d.sck_prev = sck_s;
        rise          = sck_s & ~sq_q.sck_prev & ~held;
        fall          = ~sck_s & sq_q.sck_prev & ~held;
        rx_next       = {sq_q.rx_sr[BYTE_W-2:0], si_s};
        if (cs_hi) begin
            sq_d.cnt   = '0;
            sq_d.rx_sr = '0;
            sq_d.tx_sr = '0;
            sq_d.so    = 1'b0;
        end else begin
            if (rise) begin
                sq_d.rx_sr = rx_next;
                if (sq_q.cnt == LAST) begin
                    sq_d.done    = 1'b1;
                    sq_d.rx_byte = rx_next;
                    sq_d.cnt     = '0;
                end else begin
                    sq_d.cnt = sq_q.cnt + CNT_W'(1);
                end
            end
            if (fall) begin
                sq_d.so    = sq_q.tx_sr[BYTE_W-1];
                sq_d.tx_sr = {sq_q.tx_sr[BYTE_W-2:0], 1'b0};
            end
            if (load) begin
                sq_d.tx_sr = load_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign byte_done = sq_q.done;
    assign rx_byte   = sq_q.rx_byte;
    assign bit_zero  = (sq_q.cnt == '0);
    assign so_bit    = sq_q.so;

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !cs_hi) |=> ($stable(sq_q.cnt) && $stable(sq_q.rx_sr))); // R11
    AST_NO_BYTE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !sq_q.done); // R3
endmodule

// File: rtl/spi_mem_cmd.sv
module spi_mem_cmd
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_hi,
    input  logic              cs_rise,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              bit_zero,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic [BYTE_W-1:0] status_in,
    input  logic              wr_grant,
    output logic              load,
    output logic [BYTE_W-1:0] load_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              rd_req,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_data_valid,
    output logic              wr_to_status,
    output logic              wel_set,
    output logic              wel_clr,
    output logic              wr_start
);
    localparam int ADDR_BYTES = (ADDR_W + BYTE_W - 1) / BYTE_W;
    localparam int AL_W       = $clog2(ADDR_BYTES + 1);

    typedef struct packed {
        phase_e            phase;
        logic [BYTE_W-1:0] op;
        logic [ADDR_W-1:0] addr;
        logic [AL_W-1:0]   addr_left;
        logic              seen;
        logic              rd_req;
        logic              rd_pend;
        logic              st_pend;
        logic              load;
        logic [BYTE_W-1:0] load_byte;
        logic [BYTE_W-1:0] wr_data;
        logic              wr_dv;
        logic              wel_set;
        logic              wel_clr;
        logic              wr_start;
        logic              wr_status;
    } cmd_t;

    cmd_t cq_q, cq_d;
    logic [ADDR_W+BYTE_W-1:0] addr_cat;
    logic                     wr_ok;

    always_comb begin
        cq_d          = cq_q;
        cq_d.rd_req   = 1'b0;
        cq_d.load     = 1'b0;
        cq_d.wr_dv    = 1'b0;
        cq_d.wel_set  = 1'b0;
        cq_d.wel_clr  = 1'b0;
        cq_d.wr_start = 1'b0;
        addr_cat      = {cq_q.addr, rx_byte};
        wr_ok         = bit_zero && (cq_q.phase == PH_DATA) && cq_q.seen &&
                        ((cq_q.op == OPC_WRITE) || (cq_q.op == OPC_WRSR));

        if (cs_hi) begin
            if (cs_rise) begin
                if (wr_ok && wr_grant) begin
                    cq_d.wr_start  = 1'b1;
                    cq_d.wr_status = (cq_q.op == OPC_WRSR);
                end
                if (bit_zero && (cq_q.phase == PH_SKIP) && !cq_q.seen) begin
                    cq_d.wel_set = (cq_q.op == OPC_WREN);
                    cq_d.wel_clr = (cq_q.op == OPC_WRDI);
                end
            end
            cq_d.phase     = PH_OPC;
            cq_d.op        = '0;
            cq_d.seen      = 1'b0;
            cq_d.addr_left = '0;
            cq_d.rd_pend   = 1'b0;
            cq_d.st_pend   = 1'b0;
        end else begin
            // Hand read or status data to the output shifter
            if (cq_q.rd_pend) begin
                cq_d.load      = 1'b1;
                cq_d.load_byte = rd_data;
                cq_d.rd_pend   = 1'b0;
            end else if (cq_q.st_pend) begin
                cq_d.load      = 1'b1;
                cq_d.load_byte = status_in;
                cq_d.st_pend   = 1'b0;
            end
            // Write address advances once the byte has been handed over
            if (cq_q.wr_dv && (cq_q.op == OPC_WRITE)) begin
                cq_d.addr = cq_q.addr + ADDR_W'(1);
            end
            if (byte_done) begin
                unique case (cq_q.phase)
                    PH_OPC: begin
                        cq_d.op = rx_byte;
                        if ((rx_byte == OPC_READ) || (rx_byte == OPC_WRITE)) begin
                            cq_d.phase     = PH_ADDR;
                            cq_d.addr_left = AL_W'(ADDR_BYTES - 1);
                        end else if (rx_byte == OPC_RDSR) begin
                            cq_d.phase   = PH_DATA;
                            cq_d.st_pend = 1'b1;
                        end else if (rx_byte == OPC_WRSR) begin
                            cq_d.phase = PH_DATA;
                        end else if ((rx_byte == OPC_WREN) || (rx_byte == OPC_WRDI)) begin
                            cq_d.phase = PH_SKIP;
                        end else begin
                            cq_d.phase = PH_SKIP;
                            cq_d.seen  = 1'b1;
                        end
                    end
                    PH_ADDR: begin
                        cq_d.addr = addr_cat[ADDR_W-1:0];
                        if (cq_q.addr_left == '0) begin
                            cq_d.phase = PH_DATA;
                            if (cq_q.op == OPC_READ) begin
                                cq_d.rd_req  = 1'b1;
                                cq_d.rd_pend = 1'b1;
                            end
                        end else begin
                            cq_d.addr_left = cq_q.addr_left - AL_W'(1);
                        end
                    end
                    PH_DATA: begin
                        cq_d.seen = 1'b1;
                        if (cq_q.op == OPC_READ) begin
                            cq_d.addr    = cq_q.addr + ADDR_W'(1);
                            cq_d.rd_req  = 1'b1;
                            cq_d.rd_pend = 1'b1;
                        end else if (cq_q.op == OPC_RDSR) begin
                            cq_d.st_pend = 1'b1;
                        end else begin
                            cq_d.wr_data = rx_byte;
                            cq_d.wr_dv   = 1'b1;
                        end
                    end
                    default: begin
                        cq_d.seen = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cq_q       <= '0;
            cq_q.phase <= PH_OPC;
        end else begin
            cq_q <= cq_d;
        end
    end

    assign load          = cq_q.load;
    assign load_byte     = cq_q.load_byte;
    assign mem_addr      = cq_q.addr;
    assign rd_req        = cq_q.rd_req;
    assign wr_data       = cq_q.wr_data;
    assign wr_data_valid = cq_q.wr_dv;
    assign wr_to_status  = cq_q.wr_status;
    assign wel_set       = cq_q.wel_set;
    assign wel_clr       = cq_q.wel_clr;
    assign wr_start      = cq_q.wr_start;

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cq_q.rd_req, cq_q.wr_dv, cq_q.wr_start, cq_q.wel_set, cq_q.wel_clr})); // R9
    AST_REQ_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !(cq_q.rd_req || cq_q.wr_dv)); // R4
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
    parameter int ADDR_W      = 8,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              rd_req,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic [BYTE_W-1:0] status_in,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_data_valid,
    output logic              wr_to_status,
    output logic              wel_set,
    output logic              wel_clr,
    input  logic              wr_grant,
    output logic              wr_start
);
    localparam int PIN_W = 4;

    typedef struct packed {
        logic cs_prev;
        logic oe;
    } top_t;

    logic [PIN_W-1:0]  pins_s;
    logic              cs_hi, hold_n_s, sck_s, si_s;
    logic              held, cs_rise;
    logic              byte_done, bit_zero, load, so_bit;
    logic [BYTE_W-1:0] rx_byte, load_byte;
    top_t              tq_q, tq_d;

    spi_mem_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b1100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, hold_n, sck, si}),
        .dout (pins_s)
    );

    assign {cs_hi, hold_n_s, sck_s, si_s} = pins_s;

    spi_mem_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_hi   (cs_hi),
        .sck_s   (sck_s),
        .hold_n_s(hold_n_s),
        .held    (held)
    );

    spi_mem_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_hi    (cs_hi),
        .held     (held),
        .sck_s    (sck_s),
        .si_s     (si_s),
        .load     (load),
        .load_byte(load_byte),
        .byte_done(byte_done),
        .rx_byte  (rx_byte),
        .bit_zero (bit_zero),
        .so_bit   (so_bit)
    );

    spi_mem_cmd #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_hi        (cs_hi),
        .cs_rise      (cs_rise),
        .byte_done    (byte_done),
        .rx_byte      (rx_byte),
        .bit_zero     (bit_zero),
        .rd_data      (rd_data),
        .status_in    (status_in),
        .wr_grant     (wr_grant),
        .load         (load),
        .load_byte    (load_byte),
        .mem_addr     (mem_addr),
        .rd_req       (rd_req),
        .wr_data      (wr_data),
        .wr_data_valid(wr_data_valid),
        .wr_to_status (wr_to_status),
        .wel_set      (wel_set),
        .wel_clr      (wel_clr),
        .wr_start     (wr_start)
    );

    always_comb begin
        tq_d         = tq_q;
        tq_d.cs_prev = cs_hi;
        tq_d.oe      = ~cs_hi & ~held;
        cs_rise      = cs_hi & ~tq_q.cs_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tq_q <= '{cs_prev: 1'b1, oe: 1'b0};
        else        tq_q <= tq_d;
    end

    assign so    = so_bit;
    assign so_oe = tq_q.oe;

    AST_SO_OFF_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_hi) |-> !so_oe); // R3
    AST_SO_OFF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(held) |-> !so_oe); // R10
    AST_START_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> cs_hi); // R5
endmodule

// File: tb/spi_mem_slave_bench.sv
module spi_mem_slave_bench;
    localparam int CLK_P = 10;
    localparam int HALF  = 8 * CLK_P;
    localparam int NVEC  = 12;

    // [55:48] opcode [47:40] addr/first byte [39:32] data [31:28] bytes
    // [27:24] extra bits [23:16] exp read [15:8] exp write data
    // [7] start [6] set [5] clr [4] chk read [3] chk wdata [2] mode3 [1] exp to_status
    localparam logic [63:0] VEC [NVEC] = '{
        {8'h00, 8'h06, 8'h00, 8'h00, 4'd1, 4'd0, 8'h00, 8'h00, 8'b0100_0000},
        {8'h00, 8'h04, 8'h00, 8'h00, 4'd1, 4'd0, 8'h00, 8'h00, 8'b0010_0100},
        {8'h00, 8'h02, 8'h10, 8'h5A, 4'd3, 4'd0, 8'h00, 8'h5A, 8'b1000_1000},
        {8'h00, 8'h02, 8'h10, 8'h77, 4'd3, 4'd3, 8'h00, 8'h00, 8'b0000_0000},
        {8'h00, 8'h02, 8'h10, 8'h00, 4'd2, 4'd0, 8'h00, 8'h00, 8'b0000_0100},
        {8'h00, 8'h01, 8'h8C, 8'h00, 4'd2, 4'd0, 8'h00, 8'h8C, 8'b1000_1110},
        {8'h00, 8'h03, 8'h20, 8'hFF, 4'd3, 4'd0, 8'h85, 8'h00, 8'b0001_0000},
        {8'h00, 8'h03, 8'hFF, 8'hFF, 4'd4, 4'd0, 8'hA5, 8'h00, 8'b0001_0100},
        {8'h00, 8'h03, 8'h7F, 8'hFF, 4'd5, 4'd0, 8'h24, 8'h00, 8'b0001_0000},
        {8'h00, 8'h05, 8'hFF, 8'hFF, 4'd2, 4'd0, 8'h3C, 8'h00, 8'b0001_0100},
        {8'h00, 8'h0B, 8'h12, 8'h34, 4'd3, 4'd0, 8'h00, 8'h00, 8'b0000_0000},
        {8'h00, 8'h06, 8'h06, 8'h00, 4'd2, 4'd0, 8'h00, 8'h00, 8'b0000_0100}
    };

    logic       clk = 1'b0;
    logic       rst_n, sck, cs_n, si, hold_n, wr_grant;
    logic [7:0] status_in, rd_data, mem_addr, wr_data;
    logic       so, so_oe, rd_req, wr_data_valid, wr_to_status;
    logic       wel_set, wel_clr, wr_start;

    int n_start = 0, n_set = 0, n_clr = 0, n_rdreq = 0;
    logic [7:0] last_wd = '0, last_wa = '0;
    logic       last_ws = 1'b0;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    assign rd_data = mem_addr ^ 8'hA5;

    spi_mem_slave u_spi_mem_slave (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .rd_req(rd_req), .rd_data(rd_data),
        .status_in(status_in), .wr_data(wr_data), .wr_data_valid(wr_data_valid),
        .wr_to_status(wr_to_status), .wel_set(wel_set), .wel_clr(wel_clr),
        .wr_grant(wr_grant), .wr_start(wr_start)
    );

    always @(posedge clk) begin
        if (wr_start)      begin n_start <= n_start + 1; last_ws <= wr_to_status; end
        if (wel_set)       n_set   <= n_set + 1;
        if (wel_clr)       n_clr   <= n_clr + 1;
        if (rd_req)        n_rdreq <= n_rdreq + 1;
        if (wr_data_valid) begin last_wd <= wr_data; last_wa <= mem_addr; end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_bit(input logic b, output logic r);
        sck = 1'b0;
        si  = b;
        #HALF;
        r   = so;
        sck = 1'b1;
        #HALF;
    endtask

    task automatic do_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            logic bb;
            do_bit(tx[i], bb);
            rx[i] = bb;
        end
    endtask

    task automatic begin_cs(input bit m3);
        sck = m3;
        #HALF;
        cs_n = 1'b0;
        #HALF;
    endtask

    task automatic end_cs(input bit m3);
        if (!m3) begin
            sck = 1'b0;
            #HALF;
        end
        cs_n = 1'b1;
        #(4*HALF);
    endtask

    initial begin
        logic [63:0] v;
        logic [7:0]  rx, tx;
        logic        bb;
        int s_start, s_set, s_clr, s_rd;

        rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0; hold_n = 1'b1;
        wr_grant = 1'b1; status_in = 8'h3C;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(so_oe == 1'b0 && wr_start == 1'b0 && rd_req == 1'b0 && wr_data_valid == 1'b0,
              "R3 reset outputs idle", {so_oe, wr_start, rd_req, wr_data_valid}, 0);
        rst_n = 1'b1;
        #(4*HALF);
        check(so_oe == 1'b0, "R3 deselected output released", so_oe, 0);

        // Table of complete transactions
        for (int e = 0; e < NVEC; e++) begin
            v = VEC[e];
            s_start = n_start; s_set = n_set; s_clr = n_clr;
            begin_cs(v[2]);
            rx = '0;
            for (int b = 0; b < int'(v[31:28]); b++) begin
                tx = (b == 0) ? v[55:48] : ((b == 1) ? v[47:40] : v[39:32]);
                do_byte(tx, rx);
            end
            for (int x = 0; x < int'(v[27:24]); x++) begin
                do_bit(1'b1, bb);
            end
            end_cs(v[2]);
            check({n_start - s_start == int'(v[7]), n_set - s_set == int'(v[6]),
                   n_clr - s_clr == int'(v[5])} == 3'b111,
                  $sformatf("R5 R6 R9 vector %0d pulses", e),
                  {n_start - s_start, n_set - s_set, n_clr - s_clr}, v[7:5]);
            if (v[4]) check(rx == v[23:16], $sformatf("R1 R2 R7 R8 vector %0d read byte", e), rx, v[23:16]);
            if (v[3]) check(last_wd == v[15:8], $sformatf("R12 vector %0d write byte", e), last_wd, v[15:8]);
            if (v[7]) check(last_ws == v[1], $sformatf("R5 vector %0d write target", e), last_ws, v[1]);
        end

        // R12: two data bytes, address advancing
        begin_cs(1'b0);
        do_byte(8'h02, rx); do_byte(8'h30, rx); do_byte(8'h11, rx); do_byte(8'h22, rx);
        end_cs(1'b0);
        check(last_wd == 8'h22 && last_wa == 8'h31, "R12 second data byte at next address",
              {last_wa, last_wd}, 16'h3122);

        // R6: grant withheld
        s_start = n_start;
        wr_grant = 1'b0;
        begin_cs(1'b0);
        do_byte(8'h02, rx); do_byte(8'h44, rx); do_byte(8'h99, rx);
        end_cs(1'b0);
        wr_grant = 1'b1;
        check(n_start == s_start, "R6 no start without grant", n_start - s_start, 0);

        // R3 R4: aborted partial byte does not leak into next selection
        s_set = n_set;
        begin_cs(1'b0);
        for (int i = 0; i < 5; i++) do_bit(1'b1, bb);
        end_cs(1'b0);
        begin_cs(1'b0);
        do_byte(8'h06, rx);
        end_cs(1'b0);
        check(n_set - s_set == 1, "R3 R4 fresh decode after abort", n_set - s_set, 1);

        // R10 R11: pause during a read data byte, with SI noise while paused
        s_rd = n_rdreq;
        begin_cs(1'b0);
        do_byte(8'h03, rx); do_byte(8'h40, rx);
        for (int i = 7; i >= 4; i--) begin do_bit(1'b0, bb); rx[i] = bb; end
        sck = 1'b0;
        #HALF;
        hold_n = 1'b0;
        #HALF;
        check(so_oe == 1'b0, "R10 paused output released", so_oe, 0);
        for (int k = 0; k < 3; k++) begin
            sck = 1'b1; si = ~si; #HALF;
            sck = 1'b0; #HALF;
        end
        hold_n = 1'b1;
        #HALF;
        check(so_oe == 1'b1, "R11 output back after release", so_oe, 1);
        for (int i = 3; i >= 0; i--) begin do_bit(1'b0, bb); rx[i] = bb; end
        end_cs(1'b0);
        check(rx == (8'h40 ^ 8'hA5), "R11 read resumes where paused", rx, 8'h40 ^ 8'hA5);
        check(n_rdreq - s_rd == 2, "R11 no extra bytes counted while paused", n_rdreq - s_rd, 2);

        // R10: pause request with clock high is not taken
        begin_cs(1'b0);
        do_byte(8'h02, rx); do_byte(8'h50, rx);
        for (int i = 7; i >= 4; i--) do_bit(1'b1, bb);
        hold_n = 1'b0;
        #HALF;
        check(so_oe == 1'b1, "R10 no pause when clock high", so_oe, 1);
        hold_n = 1'b1;
        #HALF;
        for (int i = 3; i >= 0; i--) do_bit(1'b0, bb);
        end_cs(1'b0);
        check(last_wd == 8'hF0 && last_wa == 8'h50, "R1 R12 byte unaffected by ignored pause",
              {last_wa, last_wd}, 16'h50F0);

        check(so_oe == 1'b0, "R3 released after final deselect", so_oe, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule